// File: doc/BRIEF.md
# Rename Dispatch Credit Limiter

This block decides, every cycle, how many instructions the rename stage may hand to the dispatch side. It works out how many free entries remain in the reorder buffer, the issue queue, the load queue and the store queue. For each queue it takes the capacity reported by the back end and subtracts the instructions that rename has already sent but that have not yet been confirmed as dispatched. It keeps its own in-flight counters for all instructions, for loads, and for stores together with atomics.

The smaller of the reorder-buffer and issue-queue credits caps the number of candidate instructions. Candidates come from the skid buffer while the stage is unblocking, and from the decode input queue otherwise. The block then walks the candidate slots from oldest to youngest. The walk stops at the first load that has no load-queue room, at the first store or atomic that has no store-queue room, and at the first slot whose destination registers exceed the free physical registers that remain. Squashed slots are consumed without being renamed.

The results are the number of slots consumed, the number actually renamed, a block-this-cycle flag and a code that names the queue that ran out.

Top module: `rename_credit_limiter`

## Requirements
- R1: The ROB credit is rob_free minus (in-flight instructions minus disp_insts), and the IQ credit is the same expression using iq_free. The limit is the smaller of the two. The full_src codes are 0 none, 1 ROB, 2 IQ, 3 LQ and 4 SQ. When the two credits are equal, the limit is attributed to the ROB.
- R2: When the selected available count is zero, nothing is consumed, block_now stays low and full_src is 0, whatever the credits are.
- R3: When the available count is non-zero and the limit is zero or negative, consumed_cnt and renamed_cnt are 0, block_now is 1 and full_src names the limiting queue.
- R4: When the limit is positive but smaller than the available count, the candidates are capped at the limit, block_now is 1 and full_src names the limiting queue.
- R5: The available count is skid_cnt while unblocking is high, and inq_cnt otherwise.
- R6: slot_kind holds 2 bits per slot, with slot i at bits [2i+1:2i] and slot 0 the oldest; the codes are 0 plain, 1 load, 2 store, 3 atomic. The LQ credit is lq_free minus (in-flight loads minus disp_loads), less the loads already renamed earlier in the walk. A load reaching the walk with an LQ credit of zero or less stops the walk at that slot and sets full_src to 3, even if the slot is squashed. This does not raise block_now.
- R7: The same rule as R6 applies to stores and atomics, using sq_free, in-flight stores and disp_stores. The stop sets full_src to 4.
- R8: A squashed slot (slot_squashed[i]) counts in consumed_cnt but not in renamed_cnt, and uses no registers or queue credits.
- R9: slot_dst holds DW bits per slot. If a slot's destination count exceeds the free registers left after the earlier slots, that slot is not consumed, the walk stops and block_now is 1, with full_src unchanged.
- R10: No more than WIDTH slots are consumed in one cycle.
- R11: Each in-flight counter adds what was renamed this cycle (all, loads, stores plus atomics) and subtracts the matching dispatched count. It is clamped at zero, and the new value is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unblocking | input | 1 | Stage is draining its skid buffer |
| inq_cnt | input | AW | Instructions waiting in the decode input queue |
| skid_cnt | input | AW | Instructions waiting in the skid buffer |
| slot_kind | input | 2*WIDTH | Per-slot instruction kind |
| slot_squashed | input | WIDTH | Per-slot squashed flag |
| slot_dst | input | DW*WIDTH | Per-slot destination register count |
| rob_free | input | CW | Reported free ROB entries |
| iq_free | input | CW | Reported free IQ entries |
| lq_free | input | CW | Reported free LQ entries |
| sq_free | input | CW | Reported free SQ entries |
| disp_insts | input | CW | Instructions confirmed dispatched last cycle |
| disp_loads | input | CW | Loads confirmed placed in the LQ |
| disp_stores | input | CW | Stores and atomics confirmed placed in the SQ |
| free_regs | input | RW | Free physical registers |
| consumed_cnt | output | CNTW | Slots removed from the source this cycle |
| renamed_cnt | output | CNTW | Slots renamed and sent downstream |
| block_now | output | 1 | Rename must block this cycle |
| full_src | output | 3 | Queue that ran out of room |

## Verification
A wrong in-flight counter does not appear at the ports in the cycle it goes wrong. It shows up one cycle later, as a credit that is too large or too small, and from then on as a capped count, a spurious block or a missing block whenever the reported free counts are close to the occupancy. The bench therefore keeps its own occupancy model and chooses capacities near the boundary so that a one-off error changes consumed_cnt right away. It also forces a dispatched count larger than the in-flight total, so that a missing clamp appears in the next vector as a credit wrapped negative. Errors in the walk are immediate and show up as the wrong stop slot or the wrong full_src in the same cycle.

// File: rtl/rcl_pkg.sv
package rcl_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_ATOMIC = 2'd3
  } slot_kind_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_ROB  = 3'd1,
    SRC_IQ   = 3'd2,
    SRC_LQ   = 3'd3,
    SRC_SQ   = 3'd4
  } full_src_e;

  localparam int NUM_CTR = 3;
  localparam int CTR_ALL = 0;
  localparam int CTR_LD  = 1;
  localparam int CTR_ST  = 2;

  localparam int NUM_CRD = 4;
  localparam int CRD_ROB = 0;
  localparam int CRD_IQ  = 1;
  localparam int CRD_LQ  = 2;
  localparam int CRD_SQ  = 3;

endpackage

// File: rtl/rcl_inflight.sv
module rcl_inflight #(
  parameter int CW   = 6,
  parameter int CNTW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CNTW-1:0] add_cnt,
  input  logic [CW-1:0]   sub_cnt,
  output logic [CW-1:0]   cur_cnt
);
  localparam int TW = CW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [TW-1:0] total;
  logic          cnt_en;

  always_comb begin
    total  = TW'(cnt_q) + TW'(add_cnt);
    cnt_en = (add_cnt != '0) || (sub_cnt != '0);
    if (total < TW'(sub_cnt)) begin
      cnt_d = '0;
    end else begin
      cnt_d = CW'(total - TW'(sub_cnt));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cur_cnt = cnt_q;
endmodule

// File: rtl/rcl_credit.sv
module rcl_credit #(
  parameter int CW = 6,
  parameter int SW = CW + 2
) (
  input  logic [CW-1:0]        cap_free,
  input  logic [CW-1:0]        in_flight,
  input  logic [CW-1:0]        confirmed,
  output logic signed [SW-1:0] credit
);
  logic signed [SW-1:0] pending;

  always_comb begin
    pending = $signed(SW'(in_flight)) - $signed(SW'(confirmed));
    credit  = $signed(SW'(cap_free)) - pending;
  end
endmodule

// File: rtl/rcl_slot_walk.sv
module rcl_slot_walk
  import rcl_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DW    = 3,
  parameter int RW    = 6,
  parameter int SW    = 8,
  parameter int CNTW  = $clog2(WIDTH + 1)
) (
  input  logic [CNTW-1:0]       walk_len,
  input  logic [2*WIDTH-1:0]    slot_kind,
  input  logic [WIDTH-1:0]      slot_squashed,
  input  logic [DW*WIDTH-1:0]   slot_dst,
  input  logic signed [SW-1:0]  lq_credit,
  input  logic signed [SW-1:0]  sq_credit,
  input  logic [RW-1:0]         free_regs,
  output logic [CNTW-1:0]       consumed,
  output logic [CNTW-1:0]       renamed,
  output logic [CNTW-1:0]       loads_sent,
  output logic [CNTW-1:0]       stores_sent,
  output logic                  stop_lq,
  output logic                  stop_sq,
  output logic                  stop_regs
);
  localparam logic [CNTW-1:0] ONE = CNTW'(1);

  slot_kind_e           kind;
  logic                 is_ld;
  logic                 is_st;
  logic                 halted;
  logic [RW-1:0]        regs_used;
  logic [RW-1:0]        need;
  logic signed [SW-1:0] ld_used;
  logic signed [SW-1:0] st_used;

  always_comb begin
    consumed    = '0;
    renamed     = '0;
    loads_sent  = '0;
    stores_sent = '0;
    stop_lq     = 1'b0;
    stop_sq     = 1'b0;
    stop_regs   = 1'b0;
    halted      = 1'b0;
    regs_used   = '0;
    ld_used     = '0;
    st_used     = '0;
    kind        = KIND_PLAIN;
    is_ld       = 1'b0;
    is_st       = 1'b0;
    need        = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!halted && (CNTW'(i) < walk_len)) begin
        kind  = slot_kind_e'(slot_kind[2*i +: 2]);
        is_ld = (kind == KIND_LOAD);
        is_st = (kind == KIND_STORE) || (kind == KIND_ATOMIC);
        need  = RW'(slot_dst[DW*i +: DW]);
        if (is_ld && ((lq_credit - ld_used) <= 0)) begin
          stop_lq = 1'b1;
          halted  = 1'b1;
        end else if (is_st && ((sq_credit - st_used) <= 0)) begin
          stop_sq = 1'b1;
          halted  = 1'b1;
        end else if (slot_squashed[i]) begin
          consumed = consumed + ONE;
        end else if (need > (free_regs - regs_used)) begin
          stop_regs = 1'b1;
          halted    = 1'b1;
        end else begin
          consumed  = consumed + ONE;
          renamed   = renamed + ONE;
          regs_used = regs_used + need;
          if (is_ld) begin
            loads_sent = loads_sent + ONE;
            ld_used    = ld_used + SW'(1);
          end
          if (is_st) begin
            stores_sent = stores_sent + ONE;
            st_used     = st_used + SW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/rename_credit_limiter.sv
module rename_credit_limiter
  import rcl_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int AW    = 4,
  parameter int CW    = 6,
  parameter int DW    = 3,
  parameter int RW    = 6,
  localparam int CNTW = $clog2(WIDTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                unblocking,
  input  logic [AW-1:0]       inq_cnt,
  input  logic [AW-1:0]       skid_cnt,
  input  logic [2*WIDTH-1:0]  slot_kind,
  input  logic [WIDTH-1:0]    slot_squashed,
  input  logic [DW*WIDTH-1:0] slot_dst,
  input  logic [CW-1:0]       rob_free,
  input  logic [CW-1:0]       iq_free,
  input  logic [CW-1:0]       lq_free,
  input  logic [CW-1:0]       sq_free,
  input  logic [CW-1:0]       disp_insts,
  input  logic [CW-1:0]       disp_loads,
  input  logic [CW-1:0]       disp_stores,
  input  logic [RW-1:0]       free_regs,
  output logic [CNTW-1:0]     consumed_cnt,
  output logic [CNTW-1:0]     renamed_cnt,
  output logic                block_now,
  output logic [2:0]          full_src
);
  localparam int SW = ((CW > AW) ? CW : AW) + 2;

  logic [CW-1:0]        inflight [NUM_CTR];
  logic [CNTW-1:0]      ctr_add  [NUM_CTR];
  logic [CW-1:0]        ctr_sub  [NUM_CTR];
  logic [CW-1:0]        crd_cap  [NUM_CRD];
  logic [CW-1:0]        crd_fly  [NUM_CRD];
  logic [CW-1:0]        crd_conf [NUM_CRD];
  logic signed [SW-1:0] credit   [NUM_CRD];

  logic [CNTW-1:0]      walk_consumed;
  logic [CNTW-1:0]      walk_renamed;
  logic [CNTW-1:0]      walk_loads;
  logic [CNTW-1:0]      walk_stores;
  logic                 walk_stop_lq;
  logic                 walk_stop_sq;
  logic                 walk_stop_regs;

  logic [AW-1:0]        avail_sel;
  logic signed [SW-1:0] avail_s;
  logic signed [SW-1:0] limit;
  logic signed [SW-1:0] eff;
  full_src_e            lim_src;
  full_src_e            src_d;
  logic                 cap_block;
  logic                 run_walk;
  logic [CNTW-1:0]      walk_len;

  // in-flight counters: all instructions, loads, stores+atomics
  assign ctr_add[CTR_ALL] = walk_renamed;
  assign ctr_add[CTR_LD]  = walk_loads;
  assign ctr_add[CTR_ST]  = walk_stores;
  assign ctr_sub[CTR_ALL] = disp_insts;
  assign ctr_sub[CTR_LD]  = disp_loads;
  assign ctr_sub[CTR_ST]  = disp_stores;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    rcl_inflight #(
      .CW   (CW),
      .CNTW (CNTW)
    ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_cnt (ctr_add[g]),
      .sub_cnt (ctr_sub[g]),
      .cur_cnt (inflight[g])
    );
  end

  // credit sources
  assign crd_cap[CRD_ROB]  = rob_free;
  assign crd_cap[CRD_IQ]   = iq_free;
  assign crd_cap[CRD_LQ]   = lq_free;
  assign crd_cap[CRD_SQ]   = sq_free;
  assign crd_fly[CRD_ROB]  = inflight[CTR_ALL];
  assign crd_fly[CRD_IQ]   = inflight[CTR_ALL];
  assign crd_fly[CRD_LQ]   = inflight[CTR_LD];
  assign crd_fly[CRD_SQ]   = inflight[CTR_ST];
  assign crd_conf[CRD_ROB] = disp_insts;
  assign crd_conf[CRD_IQ]  = disp_insts;
  assign crd_conf[CRD_LQ]  = disp_loads;
  assign crd_conf[CRD_SQ]  = disp_stores;

  for (genvar c = 0; c < NUM_CRD; c++) begin : g_crd
    rcl_credit #(
      .CW (CW),
      .SW (SW)
    ) u_crd (
      .cap_free  (crd_cap[c]),
      .in_flight (crd_fly[c]),
      .confirmed (crd_conf[c]),
      .credit    (credit[c])
    );
  end

  // limit and candidate count
  always_comb begin
    avail_sel = unblocking ? skid_cnt : inq_cnt;
    avail_s   = $signed(SW'(avail_sel));
    if (credit[CRD_IQ] < credit[CRD_ROB]) begin
      limit   = credit[CRD_IQ];
      lim_src = SRC_IQ;
    end else begin
      limit   = credit[CRD_ROB];
      lim_src = SRC_ROB;
    end
    run_walk  = 1'b0;
    cap_block = 1'b0;
    eff       = '0;
    if (avail_sel == '0) begin
      run_walk = 1'b0;
    end else if (limit <= 0) begin
      cap_block = 1'b1;
    end else if (limit < avail_s) begin
      cap_block = 1'b1;
      run_walk  = 1'b1;
      eff       = limit;
    end else begin
      run_walk  = 1'b1;
      eff       = avail_s;
    end
    if (!run_walk) begin
      walk_len = '0;
    end else if (eff > $signed(SW'(WIDTH))) begin
      walk_len = CNTW'(WIDTH);
    end else begin
      walk_len = CNTW'(eff);
    end
  end

  rcl_slot_walk #(
    .WIDTH (WIDTH),
    .DW    (DW),
    .RW    (RW),
    .SW    (SW),
    .CNTW  (CNTW)
  ) u_walk (
    .walk_len      (walk_len),
    .slot_kind     (slot_kind),
    .slot_squashed (slot_squashed),
    .slot_dst      (slot_dst),
    .lq_credit     (credit[CRD_LQ]),
    .sq_credit     (credit[CRD_SQ]),
    .free_regs     (free_regs),
    .consumed      (walk_consumed),
    .renamed       (walk_renamed),
    .loads_sent    (walk_loads),
    .stores_sent   (walk_stores),
    .stop_lq       (walk_stop_lq),
    .stop_sq       (walk_stop_sq),
    .stop_regs     (walk_stop_regs)
  );

  // outputs
  always_comb begin
    src_d = SRC_NONE;
    if (cap_block) begin
      src_d = lim_src;
    end
    if (walk_stop_lq) begin
      src_d = SRC_LQ;
    end else if (walk_stop_sq) begin
      src_d = SRC_SQ;
    end
  end

  assign consumed_cnt = walk_consumed;
  assign renamed_cnt  = walk_renamed;
  assign block_now    = cap_block | walk_stop_regs;
  assign full_src     = src_d;

endmodule

// File: rtl/rcl_checker.sv
module rcl_checker
  import rcl_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int AW    = 4,
  parameter int CW    = 6,
  parameter int SW    = 8,
  parameter int CNTW  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 unblocking,
  input logic [AW-1:0]        inq_cnt,
  input logic [AW-1:0]        skid_cnt,
  input logic [CW-1:0]        disp_insts,
  input logic [CNTW-1:0]      consumed_cnt,
  input logic [CNTW-1:0]      renamed_cnt,
  input logic                 block_now,
  input logic [2:0]           full_src,
  input logic [CW-1:0]        inflight_all,
  input logic signed [SW-1:0] rob_credit,
  input logic signed [SW-1:0] iq_credit
);
  logic [AW-1:0] avail_chk;
  assign avail_chk = unblocking ? skid_cnt : inq_cnt;

  // R8
  renamed_le_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    renamed_cnt <= consumed_cnt);

  // R10
  width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consumed_cnt <= CNTW'(WIDTH));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_chk == '0) |-> (consumed_cnt == '0 && !block_now && full_src == 3'd0));

  // R3
  no_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((avail_chk != '0) && ((rob_credit <= 0) || (iq_credit <= 0)))
      |-> (block_now && consumed_cnt == '0));

  // R11
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (renamed_cnt == '0 && disp_insts == '0) |=> $stable(inflight_all));

  // R6
  lq_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_src == 3'd3) |-> (consumed_cnt < CNTW'(WIDTH)));
endmodule

bind rename_credit_limiter rcl_checker #(
  .WIDTH (WIDTH),
  .AW    (AW),
  .CW    (CW),
  .SW    (SW),
  .CNTW  (CNTW)
) u_rcl_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .unblocking   (unblocking),
  .inq_cnt      (inq_cnt),
  .skid_cnt     (skid_cnt),
  .disp_insts   (disp_insts),
  .consumed_cnt (consumed_cnt),
  .renamed_cnt  (renamed_cnt),
  .block_now    (block_now),
  .full_src     (full_src),
  .inflight_all (inflight[0]),
  .rob_credit   (credit[0]),
  .iq_credit    (credit[1])
);

// File: tb/rename_credit_limiter_bench.sv
module rename_credit_limiter_bench;
  localparam int WIDTH = 4;
  localparam int AW    = 4;
  localparam int CW    = 6;
  localparam int DW    = 3;
  localparam int RW    = 6;
  localparam int CNTW  = 3;

  logic                clk;
  logic                rst_n;
  logic                unblocking;
  logic [AW-1:0]       inq_cnt;
  logic [AW-1:0]       skid_cnt;
  logic [2*WIDTH-1:0]  slot_kind;
  logic [WIDTH-1:0]    slot_squashed;
  logic [DW*WIDTH-1:0] slot_dst;
  logic [CW-1:0]       rob_free, iq_free, lq_free, sq_free;
  logic [CW-1:0]       disp_insts, disp_loads, disp_stores;
  logic [RW-1:0]       free_regs;
  logic [CNTW-1:0]     consumed_cnt;
  logic [CNTW-1:0]     renamed_cnt;
  logic                block_now;
  logic [2:0]          full_src;

  rename_credit_limiter u_rename_credit_limiter (
    .clk (clk), .rst_n (rst_n), .unblocking (unblocking),
    .inq_cnt (inq_cnt), .skid_cnt (skid_cnt),
    .slot_kind (slot_kind), .slot_squashed (slot_squashed), .slot_dst (slot_dst),
    .rob_free (rob_free), .iq_free (iq_free), .lq_free (lq_free), .sq_free (sq_free),
    .disp_insts (disp_insts), .disp_loads (disp_loads), .disp_stores (disp_stores),
    .free_regs (free_regs),
    .consumed_cnt (consumed_cnt), .renamed_cnt (renamed_cnt),
    .block_now (block_now), .full_src (full_src)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int    cons;
    int    ren;
    int    blk;
    int    src;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  int   m_all = 0, m_ld = 0, m_st = 0;
  bit   done = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic predict(input int unb, input int inq, input int skid,
                         input int kinds, input int sqsh, input int dsts,
                         input int rob, input int iq, input int lq, input int sq,
                         input int d_i, input int d_l, input int d_s, input int regs,
                         output exp_t e, output int n_ld, output int n_st);
    int avail, rob_c, iq_c, lq_c, sq_c, lim, lsrc, n, used;
    avail = (unb != 0) ? skid : inq;
    rob_c = rob - (m_all - d_i);
    iq_c  = iq  - (m_all - d_i);
    lq_c  = lq  - (m_ld - d_l);
    sq_c  = sq  - (m_st - d_s);
    lim = rob_c; lsrc = 1;
    if (iq_c < rob_c) begin lim = iq_c; lsrc = 2; end
    e.cons = 0; e.ren = 0; e.blk = 0; e.src = 0;
    n_ld = 0; n_st = 0; n = 0; used = 0;
    if (avail == 0) begin
      n = 0;
    end else if (lim <= 0) begin
      e.blk = 1; e.src = lsrc;
    end else begin
      n = avail;
      if (lim < avail) begin n = lim; e.blk = 1; e.src = lsrc; end
      if (n > WIDTH) n = WIDTH;
    end
    for (int i = 0; i < n; i++) begin
      int k, dd;
      k  = (kinds >> (2*i)) & 3;
      dd = (dsts >> (DW*i)) & 7;
      if (k == 1 && (lq_c - n_ld) <= 0) begin e.src = 3; break; end
      if (k >= 2 && (sq_c - n_st) <= 0) begin e.src = 4; break; end
      if (((sqsh >> i) & 1) != 0) begin e.cons++; continue; end
      if (dd > regs - used) begin e.blk = 1; break; end
      e.cons++; e.ren++; used += dd;
      if (k == 1) n_ld++;
      if (k >= 2) n_st++;
    end
  endtask

  // driver: applies a vector, pushes the expectation, advances the model
  task automatic drive(input int unb, input int inq, input int skid,
                       input int kinds, input int sqsh, input int dsts,
                       input int rob, input int iq, input int lq, input int sq,
                       input int d_i, input int d_l, input int d_s, input int regs,
                       input string tag);
    exp_t e;
    int nl, ns;
    @(negedge clk);
    unblocking    = (unb != 0);
    inq_cnt       = AW'(inq);
    skid_cnt      = AW'(skid);
    slot_kind     = (2*WIDTH)'(kinds);
    slot_squashed = WIDTH'(sqsh);
    slot_dst      = (DW*WIDTH)'(dsts);
    rob_free = CW'(rob); iq_free = CW'(iq); lq_free = CW'(lq); sq_free = CW'(sq);
    disp_insts = CW'(d_i); disp_loads = CW'(d_l); disp_stores = CW'(d_s);
    free_regs = RW'(regs);
    predict(unb, inq, skid, kinds, sqsh, dsts, rob, iq, lq, sq, d_i, d_l, d_s, regs, e, nl, ns);
    e.tag = tag;
    sb_q.push_back(e);
    m_all = m_all + e.ren - d_i; if (m_all < 0) m_all = 0;
    m_ld  = m_ld + nl - d_l;     if (m_ld < 0)  m_ld = 0;
    m_st  = m_st + ns - d_s;     if (m_st < 0)  m_st = 0;
  endtask

  // monitor: samples mid-cycle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, "consumed", int'(consumed_cnt), e.cons);
        check(e.tag, "renamed",  int'(renamed_cnt),  e.ren);
        check(e.tag, "block",    int'(block_now),    e.blk);
        check(e.tag, "full_src", int'(full_src),     e.src);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    unblocking = 1'b0; inq_cnt = '0; skid_cnt = '0;
    slot_kind = '0; slot_squashed = '0; slot_dst = '0;
    rob_free = '0; iq_free = '0; lq_free = '0; sq_free = '0;
    disp_insts = '0; disp_loads = '0; disp_stores = '0; free_regs = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    // reset state with no candidates (R2)
    check("R2", "reset consumed", int'(consumed_cnt), 0);
    check("R2", "reset block",    int'(block_now),    0);
    check("R2", "reset full_src", int'(full_src),     0);

    // R1 plain group renamed in full
    drive(0, 4, 0, 8'h00, 0, 12'h249, 20, 20, 8, 8, 0, 0, 0, 40, "R1");
    // R1 tie credit 2/2 attributes ROB; R4 cap
    drive(0, 4, 0, 8'h00, 0, 12'h249, 6, 6, 8, 8, 0, 0, 0, 40, "R4");
    // R1 IQ is the smaller credit
    drive(0, 5, 0, 8'h00, 0, 12'h249, 10, 8, 8, 8, 2, 0, 0, 40, "R1");
    // R3 zero ROB credit
    drive(0, 4, 0, 8'h00, 0, 12'h249, 8, 20, 8, 8, 0, 0, 0, 40, "R3");
    // R2 no candidates although credit is gone
    drive(0, 0, 0, 8'h00, 0, 12'h249, 0, 0, 8, 8, 0, 0, 0, 40, "R2");
    // R11 over-report of dispatch must clamp at zero
    drive(0, 0, 0, 8'h00, 0, 12'h249, 20, 20, 8, 8, 30, 0, 0, 40, "R11");
    drive(0, 4, 0, 8'h00, 0, 12'h249, 3, 20, 8, 8, 0, 0, 0, 40, "R11");
    // R5 source selection
    drive(1, 9, 2, 8'h00, 0, 12'h249, 40, 40, 8, 8, 3, 0, 0, 40, "R5");
    drive(0, 1, 9, 8'h00, 0, 12'h249, 40, 40, 8, 8, 2, 0, 0, 40, "R5");
    // R6 second load finds no LQ room
    drive(0, 4, 0, 8'h14, 0, 12'h249, 40, 40, 1, 8, 1, 0, 0, 40, "R6");
    // R6 squashed load still stopped by LQ
    drive(0, 2, 0, 8'h01, 1, 12'h249, 40, 40, 1, 8, 2, 0, 0, 40, "R6");
    // R7 store then atomic with one SQ entry
    drive(0, 4, 0, 8'h0E, 0, 12'h249, 40, 40, 8, 1, 0, 1, 0, 40, "R7");
    // R8 squashed slots consumed but not renamed
    drive(0, 4, 0, 8'h00, 5, 12'h249, 40, 40, 8, 8, 1, 0, 1, 40, "R8");
    // R9 second slot lacks registers
    drive(0, 4, 0, 8'h00, 0, 12'h01A, 40, 40, 8, 8, 2, 0, 0, 4, "R9");
    // R10 more candidates than width
    drive(0, 9, 0, 8'h00, 0, 12'h249, 40, 40, 8, 8, 1, 0, 0, 40, "R10");
    drive(0, 15, 0, 8'h00, 0, 12'h000, 40, 40, 8, 8, 4, 0, 0, 0, "R10");

    // mixed vectors near credit boundaries
    for (int v = 0; v < 80; v++) begin
      drive(int'($urandom_range(0, 1)), int'($urandom_range(0, 9)),
            int'($urandom_range(0, 9)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 15)), int'($urandom_range(0, 4095)),
            int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
            int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
            int'($urandom_range(0, 4)), int'($urandom_range(0, 2)),
            int'($urandom_range(0, 2)), int'($urandom_range(0, 20)), "R1");
    end

    @(negedge clk);
    #8;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule